// File: doc/BRIEF.md
# IDE Command Strobe Timing Generator

This block produces the active-low read and write command strobes for a single IDE device. A transfer request starts a cycle: the selected strobe is driven low for a programmed number of clocks, then held high for a second programmed number of clocks, and a one-cycle done pulse marks the last high clock. Each phase lasts the programmed field value plus one clock. The same timing serves PIO and DMA transfers, so a requester of either kind uses the same request port.

A 32-bit configuration register, written through a byte-enable port, holds both timing fields. It also holds three enable bits and one byte of scratch storage that software may use freely. One enable bit lets the device ready input stretch the low phase; that input is first passed through a two-flop synchronizer. The posted-write and read-ahead enable bits are stored and brought out to neighbouring logic, and they do not change the strobe timing. A request that arrives while a cycle is running sees a busy flag and is taken as soon as the running cycle gives its done pulse.

Top module: `ide_strobe_timer`

## Requirements
- R1: Reset leaves both strobes high, done low, busy low, and the register reading 32'h0000_0909 (both timing fields 9, all enables 0, scratch 0).
- R2: Register layout: low-time field in bits [12:8] (written with byte enable 1); high-time field in bits [4:0], read-ahead enable in bit 5, ready enable in bit 6 and posted-write enable in bit 7 (all written with byte enable 0). Bits [31:24] and [15:13] always read 0, and writes with byte enable 3 change nothing.
- R3: Bits [23:16] (byte enable 2) are scratch storage that reads back what was written and has no effect on strobe timing.
- R4: An accepted request with write flag 0 drives only the read strobe low, and with write flag 1 only the write strobe; the strobe stays low for low-time + 1 clocks when ready is disabled or already high. The two strobes are never low together.
- R5: After the low phase the strobe is high for high-time + 1 clocks; done is a one-clock pulse in the last of those clocks.
- R6: With ready enabled, the low phase does not end while the synchronized ready is low; ready rising during low clock N (N at least low-time + 1) gives a low phase of N + 2 clocks.
- R7: With ready disabled, a low ready input has no effect on the strobe timing.
- R8: Busy is high from the clock after acceptance until the done clock; a request held during busy is not lost and is accepted at the edge ending the done clock, so the next strobe falls in the very next clock.
- R9: A timing field written while a cycle runs does not change that cycle and applies from the next accepted request.
- R10: The posted-write and read-ahead enable bits appear on their own outputs and leave strobe timing unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_be | input | 4 | Byte enables for the register write |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read value |
| req_valid | input | 1 | Transfer request, held until accepted |
| req_write | input | 1 | 1 for a write cycle, 0 for a read cycle |
| req_busy | output | 1 | A cycle is running; a request is not taken |
| dev_ready | input | 1 | Asynchronous device ready |
| rd_strobe_n | output | 1 | Active-low read command strobe |
| wr_strobe_n | output | 1 | Active-low write command strobe |
| cyc_done | output | 1 | One-clock pulse in the last high clock of a cycle |
| posted_wr_en | output | 1 | Stored posted-write enable |
| read_ahead_en | output | 1 | Stored read-ahead enable |

## Verification
The done pulse of one cycle and the acceptance of the next request fall in the same clock, and a register write can land while a strobe is low. The bench holds a second request asserted through the whole first cycle and checks that its strobe falls in the clock right after done, with the high phase still exactly high-time + 1 clocks. It also rewrites the low-time field in mid-cycle and expects the running strobe to keep its old length while the following one takes the new length.

// File: rtl/ide_strobe_pkg.sv
package ide_strobe_pkg;

    localparam int TIME_W = 5;
    localparam int REG_W  = 32;
    localparam int BE_W   = REG_W / 8;
    localparam logic [TIME_W-1:0] TIME_RESET = TIME_W'(9);

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2
    } phase_e;

    typedef struct packed {
        logic [7:0]        scratch;
        logic [TIME_W-1:0] low_len;
        logic              post_wr;
        logic              rdy_en;
        logic              rd_ahead;
        logic [TIME_W-1:0] high_len;
    } cfg_t;

    localparam cfg_t CFG_RESET = '{
        scratch:  8'h00,
        low_len:  TIME_RESET,
        post_wr:  1'b0,
        rdy_en:   1'b0,
        rd_ahead: 1'b0,
        high_len: TIME_RESET
    };

    function automatic logic [REG_W-1:0] pack_cfg(input cfg_t c);
        logic [REG_W-1:0] v;
        v        = '0;
        v[23:16] = c.scratch;
        v[12:8]  = c.low_len;
        v[7]     = c.post_wr;
        v[6]     = c.rdy_en;
        v[5]     = c.rd_ahead;
        v[4:0]   = c.high_len;
        return v;
    endfunction

endpackage

// File: rtl/ist_cfg_reg.sv
module ist_cfg_reg
    import ide_strobe_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [BE_W-1:0]  be,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata,
    output cfg_t             cfg
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= CFG_RESET;
        end else if (wr_en) begin
            if (be[0]) begin
                cfg.high_len <= wdata[4:0];
                cfg.rd_ahead <= wdata[5];
                cfg.rdy_en   <= wdata[6];
                cfg.post_wr  <= wdata[7];
            end
            if (be[1]) cfg.low_len <= wdata[12:8];
            if (be[2]) cfg.scratch <= wdata[23:16];
        end
    end

    assign rdata = pack_cfg(cfg);

    // R2: register content only moves on a write
    a_r2_hold_without_write: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(rdata));

    // R2: the top byte never reacts to its enable
    a_r2_top_byte_inert: assert property (@(posedge clk) disable iff (rst)
        (wr_en && be == 4'b1000) |=> $stable(rdata));

endmodule

// File: rtl/ist_ready_sync.sv
module ist_ready_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_async,
    output logic d_sync
);

    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= d_async;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[STAGES-2:0], d_async};
            end
        end
    endgenerate

    assign d_sync = chain[STAGES-1];

    // R6: the synchronized output follows the input delayed by the chain
    a_r6_sync_delay: assert property (@(posedge clk) disable iff (rst)
        (chain[0] && !rst) |=> ($past(chain[0]) == chain[STAGES-1]) || (STAGES != 2));

endmodule

// File: rtl/ist_strobe_fsm.sv
module ist_strobe_fsm
    import ide_strobe_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  cfg_t cfg,
    input  logic rdy_sync,
    input  logic req_valid,
    input  logic req_write,
    output logic req_busy,
    output logic rd_strobe_n,
    output logic wr_strobe_n,
    output logic cyc_done
);

    phase_e            phase;
    logic [TIME_W-1:0] cnt;
    logic [TIME_W-1:0] low_q;
    logic [TIME_W-1:0] high_q;
    logic              wr_q;
    logic              rdy_en_q;

    logic at_low_end;
    logic low_release;
    logic accept;

    always_comb begin
        at_low_end  = (cnt == low_q);
        low_release = at_low_end && (!rdy_en_q || rdy_sync);
        cyc_done    = (phase == PH_HIGH) && (cnt == high_q);
        req_busy    = (phase != PH_IDLE) && !cyc_done;
        accept      = req_valid && !req_busy;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_IDLE;
            cnt      <= '0;
            low_q    <= TIME_RESET;
            high_q   <= TIME_RESET;
            wr_q     <= 1'b0;
            rdy_en_q <= 1'b0;
        end else if (accept) begin
            phase    <= PH_LOW;
            cnt      <= '0;
            low_q    <= cfg.low_len;
            high_q   <= cfg.high_len;
            wr_q     <= req_write;
            rdy_en_q <= cfg.rdy_en;
        end else begin
            unique case (phase)
                PH_LOW: begin
                    if (low_release) begin
                        phase <= PH_HIGH;
                        cnt   <= '0;
                    end else if (!at_low_end) begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_HIGH: begin
                    if (cyc_done) phase <= PH_IDLE;
                    else          cnt   <= cnt + 1'b1;
                end
                default: cnt <= '0;
            endcase
        end
    end

    assign rd_strobe_n = !((phase == PH_LOW) && !wr_q);
    assign wr_strobe_n = !((phase == PH_LOW) && wr_q);

    // R1: reset returns the strobes high and clears done
    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (rd_strobe_n && wr_strobe_n && !cyc_done && !req_busy));

    // R4: the two strobes never fall together
    a_r4_one_strobe: assert property (@(posedge clk) disable iff (rst)
        (rd_strobe_n || wr_strobe_n));

    // R5: done lasts a single clock and comes while both strobes are high
    a_r5_done_pulse: assert property (@(posedge clk) disable iff (rst)
        cyc_done |-> (rd_strobe_n && wr_strobe_n) ##1 !cyc_done);

    // R6: with ready enabled and sampled low the strobe stays low
    a_r6_wait_holds: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_LOW && rdy_en_q && !rdy_sync) |=> (phase == PH_LOW));

    // R8: a held request is not taken while busy
    a_r8_no_restart_busy: assert property (@(posedge clk) disable iff (rst)
        (req_busy && phase == PH_HIGH) |=> (phase == PH_HIGH));

    // R9: the latched lengths stay fixed for the whole cycle
    a_r9_len_stable: assert property (@(posedge clk) disable iff (rst)
        (req_busy && !accept) |=> ($stable(low_q) && $stable(high_q)));

endmodule

// File: rtl/ide_strobe_timer.sv
module ide_strobe_timer
    import ide_strobe_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_wr_en,
    input  logic [3:0]  cfg_be,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    input  logic        req_valid,
    input  logic        req_write,
    output logic        req_busy,
    input  logic        dev_ready,
    output logic        rd_strobe_n,
    output logic        wr_strobe_n,
    output logic        cyc_done,
    output logic        posted_wr_en,
    output logic        read_ahead_en
);

    cfg_t cfg;
    logic rdy_sync;

    ist_cfg_reg u_cfg (
        .clk   (clk),
        .rst   (rst),
        .wr_en (cfg_wr_en),
        .be    (cfg_be),
        .wdata (cfg_wdata),
        .rdata (cfg_rdata),
        .cfg   (cfg)
    );

    ist_ready_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async (dev_ready),
        .d_sync  (rdy_sync)
    );

    ist_strobe_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .cfg         (cfg),
        .rdy_sync    (rdy_sync),
        .req_valid   (req_valid),
        .req_write   (req_write),
        .req_busy    (req_busy),
        .rd_strobe_n (rd_strobe_n),
        .wr_strobe_n (wr_strobe_n),
        .cyc_done    (cyc_done)
    );

    assign posted_wr_en  = cfg.post_wr;
    assign read_ahead_en = cfg.rd_ahead;

    // R10: exported enables track the register bits
    a_r10_enables_out: assert property (@(posedge clk) disable iff (rst)
        (posted_wr_en == cfg_rdata[7]) && (read_ahead_en == cfg_rdata[5]));

endmodule

// File: tb/ide_strobe_timer_bench.sv
module ide_strobe_timer_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr_en = 1'b0;
    logic [3:0]  cfg_be = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic        req_busy;
    logic        dev_ready = 1'b0;
    logic        rd_strobe_n;
    logic        wr_strobe_n;
    logic        cyc_done;
    logic        posted_wr_en;
    logic        read_ahead_en;

    always #2.5 clk = ~clk;

    ide_strobe_timer u_ide_strobe_timer (.*);

    typedef struct {
        bit    wr;
        int    low;
        int    high;
        int    gap;
        string tag;
    } item_t;

    item_t exp_q[$];
    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    task automatic chk(string tag, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic cfg_write(logic [3:0] be, logic [31:0] d);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_be = be; cfg_wdata = d;
        @(negedge clk);
        cfg_wr_en = 1'b0; cfg_be = '0;
    endtask

    // driver: pushes the expected item, then requests until accepted
    task automatic do_xfer(bit wr, int low, int high, int gap, string tag, int rel);
        bit g;
        item_t it;
        it.wr = wr; it.low = low; it.high = high; it.gap = gap; it.tag = tag;
        exp_q.push_back(it);
        req_valid = 1'b1; req_write = wr;
        do begin
            g = !req_busy;
            @(negedge clk);
        end while (!g);
        req_valid = 1'b0;
        if (rel > 0) begin
            repeat (rel - 1) @(negedge clk);
            dev_ready = 1'b1;
            while (!cyc_done) @(negedge clk);
            @(negedge clk);
            dev_ready = 1'b0;
        end
    endtask

    task automatic drain();
        while (exp_q.size() != 0 || req_busy) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // monitor: measures each strobe and compares against the queue
    initial begin
        bit in_low = 0, in_high = 0, cur_wr = 0;
        int low_cnt = 0, high_cnt = 0, idle_cnt = 0;
        item_t it;
        forever begin
            @(negedge clk);
            if (rst) continue;
            if (!rd_strobe_n && !wr_strobe_n)
                chk("R4 both strobes low", 1, 0);
            if (!rd_strobe_n || !wr_strobe_n) begin
                if (!in_low) begin
                    if (exp_q.size() != 0 && exp_q[0].gap >= 0)
                        chk({exp_q[0].tag, " R8 gap after done"}, idle_cnt, exp_q[0].gap);
                    in_low = 1; in_high = 0; low_cnt = 0;
                    cur_wr = !wr_strobe_n;
                end
                low_cnt++;
            end else begin
                if (in_low) begin
                    in_low = 0; in_high = 1; high_cnt = 0;
                end
                if (in_high) high_cnt++;
                else         idle_cnt++;
            end
            if (cyc_done) begin
                if (!in_high || exp_q.size() == 0) begin
                    chk("R5 unexpected done", 1, 0);
                end else begin
                    it = exp_q.pop_front();
                    chk({it.tag, " R4 strobe select"}, int'(cur_wr), int'(it.wr));
                    chk({it.tag, " R4/R6 low clocks"}, low_cnt, it.low);
                    chk({it.tag, " R5 high clocks"}, high_cnt, it.high);
                end
                in_high = 0; idle_cnt = 0;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset values
        chk("R1 rdata", int'(cfg_rdata), 32'h0000_0909);
        chk("R1 strobes", int'({rd_strobe_n, wr_strobe_n}), 3);
        chk("R1 busy/done", int'({req_busy, cyc_done}), 0);

        // R4 R5 default timing: 10 low, 10 high
        do_xfer(1'b0, 10, 10, -1, "default read", 0);
        drain();

        // R2 layout and reserved bits
        cfg_write(4'hF, 32'hFFFF_FFFF);
        @(negedge clk);
        chk("R2 all ones", int'(cfg_rdata), 32'h00FF_1FFF);
        chk("R10 exported enables", int'({posted_wr_en, read_ahead_en}), 3);
        cfg_write(4'b1000, 32'h0000_0000);
        chk("R2 top byte inert", int'(cfg_rdata), 32'h00FF_1FFF);
        cfg_write(4'b0011, 32'h0000_0302);
        chk("R2 byte 0/1 fields", int'(cfg_rdata), 32'h00FF_0302);
        chk("R10 enables cleared", int'({posted_wr_en, read_ahead_en}), 0);

        // R3 scratch byte has no effect on timing
        cfg_write(4'b0100, 32'h00A5_0000);
        chk("R3 scratch readback", int'(cfg_rdata), 32'h00A5_0302);
        do_xfer(1'b1, 4, 3, -1, "scratch write", 0);
        drain();

        // R10 enables on, timing unchanged
        cfg_write(4'b0001, 32'h0000_00A2);
        chk("R10 enable bits", int'({posted_wr_en, read_ahead_en}), 3);
        do_xfer(1'b0, 4, 3, -1, "R10 read", 0);
        drain();

        // R7 ready disabled, ready low ignored
        cfg_write(4'b0011, 32'h0000_0201);
        dev_ready = 1'b0;
        do_xfer(1'b1, 3, 2, -1, "R7 ignore ready", 0);
        drain();

        // R6 ready enabled, held low then released in low clock 6
        cfg_write(4'b0001, 32'h0000_0041);
        do_xfer(1'b0, 8, 2, -1, "R6 wait", 6);
        drain();
        // R6 ready enabled and already high: no stretch
        dev_ready = 1'b1;
        repeat (3) @(negedge clk);
        do_xfer(1'b1, 3, 2, -1, "R6 ready high", 0);
        drain();
        dev_ready = 1'b0;
        cfg_write(4'b0001, 32'h0000_0003);

        // R8 back-to-back: second request held during busy
        cfg_write(4'b0010, 32'h0000_0100);
        do_xfer(1'b0, 2, 4, -1, "R8 first", 0);
        @(negedge clk);
        chk("R8 busy during cycle", int'(req_busy), 1);
        do_xfer(1'b1, 2, 4, 0, "R8 second", 0);
        drain();

        // R9 timing change during a running cycle
        cfg_write(4'b0010, 32'h0000_0300);
        fork
            do_xfer(1'b0, 4, 4, -1, "R9 old length", 0);
            begin
                repeat (2) @(negedge clk);
                cfg_wr_en = 1'b1; cfg_be = 4'b0010; cfg_wdata = 32'h0000_0700;
                @(negedge clk);
                cfg_wr_en = 1'b0; cfg_be = '0;
            end
        join
        drain();
        do_xfer(1'b1, 8, 4, -1, "R9 new length", 0);
        drain();

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule